// File: doc/BRIEF.md
# Phase-Aware Stall Controller for a Wrapped Synchronous Module

This block sits beside a synchronous module that has several communication channels. It decides on every clock cycle whether that module may advance. The module runs in one of two internal phases. Each phase needs its own subset of the channels. The controller raises its clock-enable only when every channel needed in the current phase reports that it is available. A channel that the current phase does not use can be missing without holding the module back. This removes stalls that would occur if every channel had to be available on every cycle.

Each channel supplies one availability flag. For an input channel, the flag means valid data is waiting. For an output channel, it means the channel can accept a word. The controller registers the flags on the rising edge of the free-running clock. It then forms the enable from the registered flags and the current phase. A register on the falling edge captures the enable, so the enable that feeds the clock-gating cell or the clock-enable pins of the module's flops never changes while the clock is high. The phase bit is held in a flop whose enable is that registered enable, so the phase holds whenever the module is stalled. Channel 0 is called a, channel 1 is b and channel 2 is c.

Top module: `stall_wrapper_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `phase_o` becomes 0. While `rst_n` is low at a falling edge, `mod_clk_en_o` becomes 0. Reset is synchronous and active low.
- R2: A change on `chan_ok_i` is captured at the next rising edge. It appears on `mod_clk_en_o` at the falling edge that follows that rising edge, and not earlier.
- R3: When `phase_o` is 0, `mod_clk_en_o` goes to 1 exactly when channel a (bit 0) and channel c (bit 2) were both available.
- R4: When `phase_o` is 1, `mod_clk_en_o` goes to 1 exactly when channel b (bit 1) and channel c (bit 2) were both available.
- R5: A channel that the current phase does not need has no effect on `mod_clk_en_o`. In phase 0 this is bit 1; in phase 1 it is bit 0.
- R6: At each rising edge where `mod_clk_en_o` is 1, `phase_o` toggles exactly once: 0 becomes 1 and 1 becomes 0.
- R7: At a rising edge where `mod_clk_en_o` is 0, `phase_o` keeps its value.
- R8: With all channels available on every cycle, `mod_clk_en_o` stays 1 and `phase_o` alternates on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_ok_i | input | N_CH (3) | Availability flag per channel: bit 0 = a, bit 1 = b, bit 2 = c |
| mod_clk_en_o | output | 1 | Enable for the wrapped module's clock, registered on the falling edge |
| phase_o | output | 1 | Current phase of the wrapped module (0 or 1) |

## Verification
A phase bit that is wrong, or that has moved without an enable, shows up at the ports as an enable that follows the wrong pair of channels. Within one falling edge, a flag pattern that should stall the module instead lets it run, or the reverse. A phase that misses a toggle, or toggles twice, is visible on `phase_o` right after the rising edge concerned. The enable pattern changes from then on, so the walked vector table is built so that every transition is followed by a pattern that only the correct phase accepts.

// File: rtl/stall_pkg.sv
// Package stall_pkg
// Shared definitions for the phase-aware stall controller.
// Assumes: exactly two phases; channel masks are N_CH bits wide.
package stall_pkg;

    // Default number of channels that the wrapped module owns
    localparam int unsigned DEF_N_CH = 3;

    // Phase of the wrapped module, held in a single state bit
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Default need masks: phase 0 uses channels 0 and 2, phase 1 uses 1 and 2
    localparam logic [DEF_N_CH-1:0] DEF_NEED_P0 = 3'b101;
    localparam logic [DEF_N_CH-1:0] DEF_NEED_P1 = 3'b110;

endpackage

// File: rtl/stall_flag_sampler.sv
// Module stall_flag_sampler
// Registers the per-channel availability flags on the rising edge of the
// free-running clock. The enable logic and the next-state logic therefore
// both see one stable set of flags for the whole cycle.
// Assumes: flags are synchronous to clk.
module stall_flag_sampler #(
    parameter int unsigned N_CH = stall_pkg::DEF_N_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] avail_i,
    output logic [N_CH-1:0] avail_q
);

    // Capture the flags once per cycle; clear them in reset
    always_ff @(posedge clk) begin
        if (!rst_n) avail_q <= '0;
        else        avail_q <= avail_i;
    end

endmodule

// File: rtl/stall_phase_fsm.sv
// Module stall_phase_fsm
// Two-phase state machine of the wrapped module. It picks the need mask
// for the current phase and computes the fire term (all needed channels
// available). Its state flop advances only when the registered enable is
// high, which models the gated clock as a clock-enable.
// Assumes: avail_q changes only at rising edges; step_en is the fire term
// registered on the falling edge.
module stall_phase_fsm #(
    parameter int unsigned            N_CH    = stall_pkg::DEF_N_CH,
    parameter logic [N_CH-1:0]        NEED_P0 = stall_pkg::DEF_NEED_P0,
    parameter logic [N_CH-1:0]        NEED_P1 = stall_pkg::DEF_NEED_P1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic [N_CH-1:0] avail_q,
    output logic            phase_o,
    output logic            fire_o
);
    import stall_pkg::*;

    phase_e          state_q;
    logic [N_CH-1:0] need_mask;
    logic [N_CH-1:0] chan_sat;
    logic            next_y;

    // Select the channels that the current phase depends on
    always_comb begin
        need_mask = (state_q == PH_FIRST) ? NEED_P0 : NEED_P1;
    end

    // A channel is satisfied if it is available or not needed now
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sat
        assign chan_sat[ch] = avail_q[ch] | ~need_mask[ch];
    end

    // Fire term and next-state value (next is 1 only when firing in phase 0)
    always_comb begin
        fire_o = &chan_sat;
        next_y = (state_q == PH_FIRST) && fire_o;
    end

    // State flop on the modelled gated clock
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= PH_FIRST;
        else if (step_en) state_q <= phase_e'(next_y);
    end

    assign phase_o = state_q;

    // R6
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (phase_o != $past(phase_o)));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase_o));

    // R1
    phase_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_o == 1'b0));

endmodule

// File: rtl/stall_enable_reg.sv
// Module stall_enable_reg
// Captures the fire term on the falling clock edge. The enable that reaches
// the clock gate or the clock-enable pins is then steady while clk is high.
// Assumes: fire_i settles within half a clock period after the rising edge.
module stall_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic en_q
);

    // Falling-edge capture of the enable; cleared in reset
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fire_i;
    end

    // R1
    en_reset_chk: assert property (@(negedge clk)
        !rst_n |=> !en_q);

endmodule

// File: rtl/stall_wrapper_ctrl.sv
// Module stall_wrapper_ctrl
// Top of the phase-aware stall controller. Flags are sampled at the rising
// edge. The fire term is built from the current phase's need mask and is
// registered at the falling edge into the module clock-enable. The phase
// advances only on enabled cycles.
// Assumes: a single free-running clock; synchronous active-low reset.
module stall_wrapper_ctrl #(
    parameter int unsigned     N_CH    = stall_pkg::DEF_N_CH,
    parameter logic [N_CH-1:0] NEED_P0 = stall_pkg::DEF_NEED_P0,
    parameter logic [N_CH-1:0] NEED_P1 = stall_pkg::DEF_NEED_P1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_ok_i,
    output logic            mod_clk_en_o,
    output logic            phase_o
);

    logic [N_CH-1:0] flags_q;
    logic            fire;

    stall_flag_sampler #(.N_CH(N_CH)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .avail_i (chan_ok_i),
        .avail_q (flags_q)
    );

    stall_phase_fsm #(
        .N_CH    (N_CH),
        .NEED_P0 (NEED_P0),
        .NEED_P1 (NEED_P1)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (mod_clk_en_o),
        .avail_q (flags_q),
        .phase_o (phase_o),
        .fire_o  (fire)
    );

    stall_enable_reg u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .en_q   (mod_clk_en_o)
    );

    // R3 R4
    en_needs_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_clk_en_o |-> ((flags_q & (phase_o ? NEED_P1 : NEED_P0))
                          == (phase_o ? NEED_P1 : NEED_P0)));

    // R5
    unneeded_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & (phase_o ? NEED_P1 : NEED_P0))
         == (phase_o ? NEED_P1 : NEED_P0)) |-> mod_clk_en_o);

endmodule

// File: tb/tb_stall_wrapper_ctrl.sv
module tb_stall_wrapper_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 20;

    // Row layout: [8:5] requirement, [4] expected enable, [3] expected phase,
    // [2:0] flags {c,b,a}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd3, 1'b0, 1'b0, 3'b000},  // R3 nothing available
        {4'd5, 1'b0, 1'b0, 3'b010},  // R5 only unneeded b
        {4'd3, 1'b0, 1'b0, 3'b001},  // R3 a without c
        {4'd3, 1'b0, 1'b0, 3'b100},  // R3 c without a
        {4'd3, 1'b0, 1'b0, 3'b011},  // R3 a and b, no c
        {4'd3, 1'b1, 1'b0, 3'b101},  // R3 a and c fire
        {4'd5, 1'b0, 1'b1, 3'b101},  // R5 phase 1 ignores a
        {4'd4, 1'b0, 1'b1, 3'b100},  // R4 c without b
        {4'd4, 1'b0, 1'b1, 3'b011},  // R4 b without c
        {4'd4, 1'b1, 1'b1, 3'b110},  // R4 b and c fire
        {4'd5, 1'b0, 1'b0, 3'b110},  // R5 phase 0 ignores b
        {4'd8, 1'b1, 1'b0, 3'b111},  // R8 all available
        {4'd8, 1'b1, 1'b1, 3'b111},
        {4'd8, 1'b1, 1'b0, 3'b111},
        {4'd8, 1'b1, 1'b1, 3'b111},
        {4'd8, 1'b1, 1'b0, 3'b111},
        {4'd4, 1'b0, 1'b1, 3'b010},  // R4 b alone
        {4'd7, 1'b0, 1'b1, 3'b000},  // R7 phase holds while stalled
        {4'd6, 1'b1, 1'b1, 3'b110},  // R6 toggle back to 0
        {4'd7, 1'b0, 1'b0, 3'b000}   // R7 hold after toggle
    };

    logic       clk;
    logic       rst_n;
    logic [2:0] chan_ok;
    logic       en;
    logic       phase;
    int         total;
    int         bad;
    bit         done;

    stall_wrapper_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_ok_i    (chan_ok),
        .mod_clk_en_o (en),
        .phase_o      (phase)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic check_req(input logic act, input logic exp, input int r,
                             input string what);
        check(act, exp, $sformatf("R%0d", r), what);
    endtask

    initial begin
        total = 0;
        bad = 0;
        done = 1'b0;
        rst_n = 1'b0;
        chan_ok = 3'b111;
        repeat (3) @(negedge clk);
        #1;
        check(en, 1'b0, "R1", "enable in reset");
        check(phase, 1'b0, "R1", "phase in reset");

        // R2: release reset, flags already all available
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(en, 1'b0, "R2", "enable before falling edge");
        check(phase, 1'b0, "R2", "phase before enable");
        @(negedge clk); #1;
        check(en, 1'b1, "R2", "enable after falling edge");
        @(posedge clk); #1;
        check(phase, 1'b1, "R6", "phase after first enabled edge");

        // R1: reset in mid-run while the module is running
        rst_n = 1'b0;
        chan_ok = 3'b000;
        @(negedge clk); #1;
        check(en, 1'b0, "R1", "enable cleared by mid-run reset");
        @(posedge clk); #1;
        check(phase, 1'b0, "R1", "phase cleared by mid-run reset");
        @(negedge clk); #1;
        rst_n = 1'b1;

        // Vector walk, one row per clock cycle
        for (int i = 0; i < NVEC; i++) begin
            chan_ok = VEC[i][2:0];
            @(posedge clk); #1;
            check_req(phase, VEC[i][3], int'(VEC[i][8:5]), $sformatf("phase row %0d", i));
            @(negedge clk); #1;
            check_req(en, VEC[i][4], int'(VEC[i][8:5]), $sformatf("enable row %0d", i));
        end
        @(posedge clk); #1;
        check(phase, 1'b0, "R7", "final phase");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule